// File: doc/BRIEF.md
# Extended-Dividend Integer Divider

This block performs integer division over several cycles for an integer execution pipeline. In its two narrow modes the dividend is twice the result width. Its upper half comes from a separate Y operand and its lower half from the low half of the first source operand. A narrow quotient that does not fit in half the datapath width is clamped to a fixed limit, and the block raises an overflow flag. The pipeline uses that flag to update its condition codes. In its two wide modes the block divides the full first source operand by the full divisor. The Y operand is not used and no clamping takes place.

The block has a plain handshake. When the block is idle, a one-cycle `start` captures the mode and all three operands. `busy` then stays high while the work runs. `done` is high for a single cycle when the result registers have been updated. A zero divisor does not start any iteration. The block reports the divide-by-zero fault and leaves the quotient output unchanged. Decoding the instruction and delivering the trap are left to the surrounding pipeline.

Internally the divider works on magnitudes. It uses a restoring shift-and-subtract step that yields one quotient bit per cycle. For the signed modes the sign is restored after the last step, so the quotient truncates toward zero.

Top module: `wide_dividend_div`

## Requirements
- R1: The mode is `mode[1:0]`. Bit 1 selects wide (1) or narrow (0), and bit 0 selects signed (1) or unsigned (0). In mode 0 (narrow unsigned) the dividend is the unsigned value {y_in, rs1_in[HALF-1:0]} and the divisor is divisor_in[HALF-1:0] zero-extended. When the true quotient is below 2^HALF, `quotient` is that quotient zero-extended to XLEN bits and `overflow` is 0.
- R2: In mode 0, a true quotient of 2^HALF or more gives `quotient` = 2^HALF-1 (upper half zero, lower half all ones) with `overflow` = 1.
- R3: In mode 1 (narrow signed) the dividend is {y_in, rs1_in[HALF-1:0]} read as a signed XLEN-bit value. The divisor is divisor_in[HALF-1:0] read as signed. The quotient truncates toward zero. When it lies in [-2^(HALF-1), 2^(HALF-1)-1], `quotient` is its XLEN-bit two's complement form and `overflow` is 0.
- R4: In mode 1, a quotient above 2^(HALF-1)-1 gives `quotient` = 2^(HALF-1)-1. A quotient below -2^(HALF-1) gives the sign-extended value -2^(HALF-1). Both set `overflow` = 1.
- R5: In mode 2 (wide unsigned), `quotient` is rs1_in / divisor_in, with both operands unsigned at their full XLEN width. y_in is ignored and `overflow` is 0.
- R6: In mode 3 (wide signed), `quotient` is the low XLEN bits of the quotient truncated toward zero, with both operands read as signed at full width. The most negative value divided by -1 therefore gives the most negative value. y_in is ignored and `overflow` is 0.
- R7: The divisor is zero when its low HALF bits are zero in the narrow modes, or when all XLEN bits are zero in the wide modes. A zero divisor gives `div_zero` = 1 and `overflow` = 0, and `quotient` keeps the value of the last successful division. `done` follows 2 rising edges after the edge that sampled `start`. Any other divisor gives `div_zero` = 0.
- R8: For a nonzero divisor, `done` is high in the cycle after the (XLEN+2)-th rising edge following the edge that sampled `start`. `done` is high for exactly one cycle. `busy` is high from the cycle after that edge until `done` rises, and is never high together with `done`.
- R9: A `start` that arrives while `busy` is high is ignored. It neither changes the running result nor begins a second operation.
- R10: After reset, `busy`, `done`, `overflow` and `div_zero` are 0 and `quotient` is all zeros. The values of `quotient`, `overflow` and `div_zero` hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division; sampled only while idle |
| mode | input | 2 | Bit 1: wide, bit 0: signed |
| y_in | input | HALF | Upper half of the narrow-mode dividend |
| rs1_in | input | XLEN | Source operand: low half in narrow modes, full in wide modes |
| divisor_in | input | XLEN | Divisor: low half in narrow modes, full in wide modes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | XLEN | Result, held between operations |
| overflow | output | 1 | Narrow result was clamped |
| div_zero | output | 1 | Divisor was zero; quotient left unchanged |

## Verification
The bench sweeps all four modes on an 8-bit datapath and computes each expected quotient with the bench's own integer arithmetic. The narrow sweeps reach both clamp directions. A design that compared the signed bound the wrong way would misreport a quotient of exactly -2^(HALF-1). A design that used the unsigned limit for signed results would return the wrong saturation pattern. Divisors with only their upper half set are used in narrow mode, where they must fault, and in wide mode, where they must not. This exposes a zero test made at the wrong width. The most-negative-by-minus-one case and the fault cases check that the quotient wraps or holds as required. A start raised in the middle of an operation must leave the result and the timing untouched.

// File: rtl/wdd_pkg.sv
package wdd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIN   = 2'd3
  } wdd_state_e;

  localparam int unsigned MODE_SIGNED_BIT = 0;
  localparam int unsigned MODE_WIDE_BIT   = 1;
endpackage

// File: rtl/wdd_rst_sync.sv
module wdd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;
endmodule

// File: rtl/wdd_operand_prep.sv
module wdd_operand_prep #(
  parameter int unsigned XLEN = 64
) (
  input  logic [1:0]        mode,
  input  logic [XLEN/2-1:0] y_val,
  input  logic [XLEN-1:0]   src_val,
  input  logic [XLEN-1:0]   dvsr_val,
  output logic [XLEN-1:0]   dd_mag,
  output logic [XLEN-1:0]   dv_mag,
  output logic              q_neg,
  output logic              dv_zero
);
  import wdd_pkg::*;
  localparam int unsigned HALF = XLEN / 2;

  logic            is_signed;
  logic            is_wide;
  logic [XLEN-1:0] dd_raw;
  logic [XLEN-1:0] dv_raw;
  logic            dd_neg;
  logic            dv_neg;

  assign is_signed = mode[MODE_SIGNED_BIT];
  assign is_wide   = mode[MODE_WIDE_BIT];

  always_comb begin
    if (is_wide) begin
      dd_raw = src_val;
      dv_raw = dvsr_val;
    end else begin
      dd_raw = {y_val, src_val[HALF-1:0]};
      if (is_signed) dv_raw = {{HALF{dvsr_val[HALF-1]}}, dvsr_val[HALF-1:0]};
      else           dv_raw = {{HALF{1'b0}}, dvsr_val[HALF-1:0]};
    end
  end

  assign dd_neg  = is_signed & dd_raw[XLEN-1];
  assign dv_neg  = is_signed & dv_raw[XLEN-1];
  assign dd_mag  = dd_neg ? (~dd_raw + XLEN'(1)) : dd_raw;
  assign dv_mag  = dv_neg ? (~dv_raw + XLEN'(1)) : dv_raw;
  assign q_neg   = dd_neg ^ dv_neg;
  assign dv_zero = (dv_raw == '0);
endmodule

// File: rtl/wdd_restore_core.sv
module wdd_restore_core #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic [XLEN-1:0] quo_mag
);
  logic [XLEN-1:0] rem_q, rem_d;
  logic [XLEN-1:0] quo_q, quo_d;
  logic [XLEN-1:0] dvs_q;
  logic [XLEN:0]   shifted;
  logic [XLEN:0]   diff;
  logic            fits;

  always_comb begin
    shifted = {rem_q, quo_q[XLEN-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = ~diff[XLEN];
    rem_d   = fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
    quo_d   = {quo_q[XLEN-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
    end else if (step) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
    end
  end

  assign quo_mag = quo_q;
endmodule

// File: rtl/wdd_result_fix.sv
module wdd_result_fix #(
  parameter int unsigned XLEN = 64
) (
  input  logic [1:0]      mode,
  input  logic            q_neg,
  input  logic [XLEN-1:0] mag,
  output logic [XLEN-1:0] result,
  output logic            ovf
);
  import wdd_pkg::*;
  localparam int unsigned HALF = XLEN / 2;
  localparam logic [XLEN-1:0] LIM_U   = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [XLEN-1:0] LIM_POS = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [XLEN-1:0] LIM_NEG = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

  logic [XLEN-1:0] signed_val;
  logic            big_u;
  logic            big_pos;
  logic            big_neg;

  assign signed_val = q_neg ? (~mag + XLEN'(1)) : mag;
  assign big_u      = |mag[XLEN-1:HALF];
  assign big_pos    = |mag[XLEN-1:HALF-1];
  assign big_neg    = big_u | (mag[HALF-1] & (|mag[HALF-2:0]));

  always_comb begin
    result = signed_val;
    ovf    = 1'b0;
    if (!mode[MODE_WIDE_BIT]) begin
      if (!mode[MODE_SIGNED_BIT]) begin
        if (big_u) begin
          result = LIM_U;
          ovf    = 1'b1;
        end
      end else if (q_neg) begin
        if (big_neg) begin
          result = LIM_NEG;
          ovf    = 1'b1;
        end
      end else if (big_pos) begin
        result = LIM_POS;
        ovf    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wide_dividend_div.sv
module wide_dividend_div #(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [XLEN/2-1:0] y_in,
  input  logic [XLEN-1:0]   rs1_in,
  input  logic [XLEN-1:0]   divisor_in,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   quotient,
  output logic              overflow,
  output logic              div_zero
);
  import wdd_pkg::*;
  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned CNT_W = $clog2(XLEN);

  logic              rst_i_n;
  wdd_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cap_en;
  logic [1:0]        mode_q;
  logic [HALF-1:0]   y_q;
  logic [XLEN-1:0]   rs1_q;
  logic [XLEN-1:0]   dv_q;
  logic              done_q, done_d;
  logic [XLEN-1:0]   quo_q, quo_d;
  logic              ovf_q, ovf_d;
  logic              dz_q, dz_d;

  logic [XLEN-1:0]   dd_mag;
  logic [XLEN-1:0]   dv_mag;
  logic              q_neg;
  logic              dv_zero;
  logic              core_load;
  logic              core_step;
  logic [XLEN-1:0]   core_quo;
  logic [XLEN-1:0]   fix_res;
  logic              fix_ovf;

  wdd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  wdd_operand_prep #(.XLEN(XLEN)) u_prep (
    .mode     (mode_q),
    .y_val    (y_q),
    .src_val  (rs1_q),
    .dvsr_val (dv_q),
    .dd_mag   (dd_mag),
    .dv_mag   (dv_mag),
    .q_neg    (q_neg),
    .dv_zero  (dv_zero)
  );

  assign core_load = (state_q == ST_SETUP) && !dv_zero;
  assign core_step = (state_q == ST_ITER);

  wdd_restore_core #(.XLEN(XLEN)) u_core (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (core_load),
    .step     (core_step),
    .dividend (dd_mag),
    .divisor  (dv_mag),
    .quo_mag  (core_quo)
  );

  wdd_result_fix #(.XLEN(XLEN)) u_fix (
    .mode   (mode_q),
    .q_neg  (q_neg),
    .mag    (core_quo),
    .result (fix_res),
    .ovf    (fix_ovf)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cap_en  = 1'b0;
    done_d  = 1'b0;
    quo_d   = quo_q;
    ovf_d   = ovf_q;
    dz_d    = dz_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        cnt_d   = '0;
        state_d = dv_zero ? ST_FIN : ST_ITER;
      end
      ST_ITER: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(XLEN - 1)) state_d = ST_FIN;
      end
      ST_FIN: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
        dz_d    = dv_zero;
        if (dv_zero) begin
          ovf_d = 1'b0;
        end else begin
          quo_d = fix_res;
          ovf_d = fix_ovf;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control and result registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      quo_q   <= '0;
      ovf_q   <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      quo_q   <= quo_d;
      ovf_q   <= ovf_d;
      dz_q    <= dz_d;
    end
  end

  // operand capture, enabled only on an accepted start
  always_ff @(posedge clk) begin
    if (cap_en) begin
      mode_q <= mode;
      y_q    <= y_in;
      rs1_q  <= rs1_in;
      dv_q   <= divisor_in;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign quotient = quo_q;
  assign overflow = ovf_q;
  assign div_zero = dz_q;
endmodule

// File: rtl/wdd_checker.sv
module wdd_checker #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [1:0]      mode,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] quotient,
  input logic            overflow,
  input logic            div_zero
);
  localparam int unsigned HALF = XLEN / 2;
  localparam logic [XLEN-1:0] LIM_U   = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [XLEN-1:0] LIM_POS = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [XLEN-1:0] LIM_NEG = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

  logic [1:0] trk_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trk_mode <= 2'b00;
    else if (start && !busy) trk_mode <= mode;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_fault_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> ($stable(quotient) && !overflow));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trk_mode[1]) |-> !overflow);

  assert_usat_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow && trk_mode == 2'd0) |-> (quotient == LIM_U));

  assert_ssat_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow && trk_mode == 2'd1) |-> (quotient == LIM_POS || quotient == LIM_NEG));
endmodule

bind wide_dividend_div wdd_checker #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .mode     (mode),
  .busy     (busy),
  .done     (done),
  .quotient (quotient),
  .overflow (overflow),
  .div_zero (div_zero)
);

// File: tb/sim_wide_dividend_div.sv
module sim_wide_dividend_div;
  localparam int unsigned X = 8;
  localparam int unsigned H = X / 2;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [1:0]   mode;
  logic [H-1:0] y_in;
  logic [X-1:0] rs1_in;
  logic [X-1:0] divisor_in;
  logic         busy;
  logic         done;
  logic [X-1:0] quotient;
  logic         overflow;
  logic         div_zero;

  int  n_cmp;
  int  n_bad;
  int  cyc;
  bit  finished;
  logic [X-1:0] last_q;

  wide_dividend_div #(.XLEN(X)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .y_in(y_in),
    .rs1_in(rs1_in), .divisor_in(divisor_in), .busy(busy), .done(done),
    .quotient(quotient), .overflow(overflow), .div_zero(div_zero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R8: act=%0d cycles exp=<190000", cyc);
        finish_run();
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] md, input logic [H-1:0] y, input logic [X-1:0] a,
                       input logic [X-1:0] b, output logic [X-1:0] er, output logic eo,
                       output logic ez);
    longint dd, dv, q;
    er = last_q; eo = 1'b0; ez = 1'b0;
    case (md)
      2'd0: begin dd = {y, a[H-1:0]}; dv = b[H-1:0]; end
      2'd1: begin dd = $signed({y, a[H-1:0]}); dv = $signed(b[H-1:0]); end
      2'd2: begin dd = a; dv = b; end
      default: begin dd = $signed(a); dv = $signed(b); end
    endcase
    if (dv == 0) begin
      ez = 1'b1;
    end else begin
      q  = dd / dv;
      er = q[X-1:0];
      if (md == 2'd0 && q > 15) begin er = 8'h0F; eo = 1'b1; end
      if (md == 2'd1 && q > 7)  begin er = 8'h07; eo = 1'b1; end
      if (md == 2'd1 && q < -8) begin er = 8'hF8; eo = 1'b1; end
    end
  endtask

  function automatic string tag_of(input logic [1:0] md);
    case (md)
      2'd0: return "R1 R2";
      2'd1: return "R3 R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // one operation; intr=1 raises a second start mid-run (R9)
  task automatic run_op(input logic [1:0] md, input logic [H-1:0] y, input logic [X-1:0] a,
                        input logic [X-1:0] b, input bit intr);
    logic [X-1:0] er;
    logic eo, ez;
    int n;
    bit busy_ok;
    model(md, y, a, b, er, eo, ez);
    @(negedge clk);
    mode = md; y_in = y; rs1_in = a; divisor_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rs1_in = ~a; divisor_in = b ^ 8'h5A; y_in = ~y; mode = ~md;
    n = 1;
    busy_ok = (busy === 1'b1) || (done === 1'b1);
    while (done !== 1'b1 && n < 100) begin
      if (intr && n == 3) start = 1'b1;
      if (intr && n == 4) start = 1'b0;
      @(negedge clk);
      n++;
      if (done !== 1'b1 && busy !== 1'b1) busy_ok = 1'b0;
    end
    start = 1'b0;
    chk({tag_of(md), ez ? " R7" : "", intr ? " R9" : "", " result"},
        {54'd0, quotient, overflow, div_zero}, {54'd0, er, eo, ez});
    chk(ez ? "R7 latency" : "R8 latency", 64'(n), ez ? 64'd3 : 64'(X + 3));
    chk("R8 busy", {63'd0, busy_ok}, 64'd1);
    if (!ez) last_q = er;
    @(negedge clk);
    chk("R8 done pulse", {63'd0, done}, 64'd0);
    if (intr) begin
      for (int k = 0; k < int'(X) + 4; k++) begin
        if (busy !== 1'b0 || done !== 1'b0) begin
          chk("R9 no second run", {62'd0, busy, done}, 64'd0);
          break;
        end
        @(negedge clk);
      end
      chk("R9 idle", {63'd0, busy}, 64'd0);
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; finished = 1'b0; last_q = '0;
    start = 1'b0; mode = 2'd0; y_in = '0; rs1_in = '0; divisor_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset", {59'd0, busy, done, overflow, div_zero, 1'b0}, 64'd0);
    chk("R10 reset quotient", {56'd0, quotient}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 after release", {56'd0, quotient}, 64'd0);

    // narrow sweeps, both saturation directions and faults
    for (int md = 0; md < 2; md++)
      for (int y = 0; y < 16; y++)
        for (int al = 0; al < 16; al += 5)
          for (int b = 0; b < 16; b++)
            run_op(2'(md), 4'(y), {4'(y) ^ 4'h9, 4'(al)}, {4'(b) ^ 4'h6, 4'(b)}, 1'b0);

    // wide sweeps with y driven to show it is ignored
    for (int md = 2; md < 4; md++)
      for (int a = 0; a < 256; a += 7)
        for (int b = 0; b < 256; b += 9)
          run_op(2'(md), 4'(a + b), 8'(a), 8'(b), 1'b0);

    // edges
    run_op(2'd3, 4'hF, 8'h80, 8'hFF, 1'b0);   // R6 min / -1 wraps
    run_op(2'd3, 4'h0, 8'h7F, 8'hFF, 1'b0);   // R6
    run_op(2'd2, 4'h3, 8'hFF, 8'h01, 1'b0);   // R5 largest
    run_op(2'd2, 4'h0, 8'h80, 8'h10, 1'b0);   // R5 upper-half-only divisor is valid
    run_op(2'd0, 4'hF, 8'hFF, 8'hF0, 1'b0);   // R7 narrow, low half zero
    run_op(2'd1, 4'h8, 8'h00, 8'h01, 1'b0);   // R4 -128 / 1 clamps negative
    run_op(2'd1, 4'hF, 8'h08, 8'h01, 1'b0);   // R3 exactly -8 fits
    run_op(2'd1, 4'h0, 8'h08, 8'h01, 1'b0);   // R4 +8 clamps positive
    run_op(2'd0, 4'hF, 8'h0F, 8'h01, 1'b0);   // R2 max
    run_op(2'd3, 4'h1, 8'h55, 8'h00, 1'b0);   // R7 wide zero
    run_op(2'd2, 4'h0, 8'hC8, 8'h07, 1'b1);   // R9 start while busy
    run_op(2'd1, 4'hE, 8'h03, 8'h03, 1'b1);   // R9 signed, interrupted
    finish_run();
  end
endmodule